// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Interface

This block is an SPI master that moves 8-bit words, most significant bit first, between two 16-entry FIFOs and a serial link. Software reaches it through a plain read/write strobe bus with three live word locations: a control and status word, a data port that pushes transmit words on write and pops receive words on read, and a clock divider. The remaining locations of the map (0x0C, 0x10, 0x14) read as zero and swallow writes.

The serial clock is the system clock divided by an even number, and every word is followed by one idle serial clock period, so a word costs nine serial clock periods. Clock polarity and phase follow the four usual SPI modes. Three chip-select lines are generated from a select code and per-line polarity bits; a three-wire read option releases the data output and takes incoming bits from the shared line. Two level interrupt sources are offered: transfer complete and receive FIFO needing service.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x0004_0000 (only "TX can accept" set), all chip-select lines are high, the serial clock is low, the interrupt is low and the data output is driven.
- R2: Byte offset 0x08 holds a 16-bit divider that reads back in bits [15:0]; offsets 0x0C, 0x10 and 0x14 read zero and ignore writes.
- R3: Each FIFO holds 16 words; a write to offset 0x04 pushes TX, a read pops RX, and a push to a full or pop from an empty FIFO is ignored. Status bits: 17 RX not empty, 18 TX not full, 19 RX holds 12 or more, 20 RX full.
- R4: The serial clock half period is D/2 system cycles where D is the divider with bit 0 forced to 0, a result of 0 from value 1 means D=2, and a stored 0 means D=65536. When no word is in flight the serial clock rests at the polarity bit (bit 3).
- R5: A word is shifted MSB first and followed by one idle serial clock period, so from the data-port write into an idle, active controller to the return of DONE is 9*D+1 system cycles.
- R6: With phase bit 2 clear, input is sampled on the leading serial clock edge and output changes on the trailing edge; with it set, output changes on the leading edge and input is sampled on the trailing edge.
- R7: Writing 1 to bit 4 (clear TX) or bit 5 (clear RX) of the control word empties that FIFO at once; both bits read back 0.
- R8: Select code bits [1:0] values 0, 1, 2 assert the matching line only while transfer-active (bit 7) is 1; code 3 asserts none.
- R9: Line i is active-high when polarity bit 21+i is set, or when global polarity bit 6 is set and i is the selected line; otherwise it is active-low.
- R10: DONE (bit 16) equals transfer-active with an empty TX FIFO and no word in flight; the interrupt is (bit 9 and DONE) or (bit 10 and status bit 19).
- R11: With read-enable bit 12 set, the data output enable is low and received bits come from the shared data line instead of the input line.
- R12: Clearing transfer-active lets the word in flight finish, starts no further word and leaves the serial clock at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops RX at the data port) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out line |
| mosi_in | input | 1 | Value seen on the shared data line |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines |

## Verification
The sharpest collision is a receive push from the shifter landing while the bus pops or clears the same FIFO, and a transmit pop at the end of a word's idle period meeting a new push from the bus. The bench provokes both by streaming many words with loopback at the shortest divider while refilling, and by filling the receive FIFO to capacity before draining it. Data order and the exact count returned are compared with a bench-side model, while the FIFO level flags are read at each threshold.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_DATA = 8'h04;
   localparam logic [7:0] OFS_DIV  = 8'h08;

   localparam int B_CPHA  = 2;
   localparam int B_CPOL  = 3;
   localparam int B_CLRTX = 4;
   localparam int B_CLRRX = 5;
   localparam int B_GPOL  = 6;
   localparam int B_ACT   = 7;
   localparam int B_IEDN  = 9;
   localparam int B_IERX  = 10;
   localparam int B_RDEN  = 12;
   localparam int B_LPOL  = 21;

   typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_GAP} eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic                       pop,
   input  logic [WIDTH-1:0]           din,
   output logic [WIDTH-1:0]           dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       empty,
   output logic                       full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("spim_fifo: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ta,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [15:0]       div,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              din,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_data,
   output logic              sclk,
   output logic              mosi,
   output logic              busy
);
   import spim_pkg::*;

   localparam int STEPS = 2 * WORD_W;
   localparam int HPW   = $clog2(STEPS);
   localparam logic [HPW-1:0] LAST = HPW'(STEPS - 1);

   generate
      if (WORD_W < 2 || WORD_W > 32) begin : g_bad_word
         $error("spim_engine: WORD_W out of range");
      end
   endgenerate

   eng_state_e        st;
   logic [HPW-1:0]    hp;
   logic [15:0]       cnt, half_m1;
   logic [WORD_W-1:0] txsr, rxsr;
   logic              tick, gap_end, start, smp, shf;

   always_comb begin
      if (div == 16'd0)             half_m1 = 16'd32767;
      else if (div[15:1] == 15'd0)  half_m1 = 16'd0;
      else                          half_m1 = {1'b0, div[15:1]} - 16'd1;
   end

   assign tick    = (cnt == 16'd0);
   assign gap_end = (st == ENG_GAP) && tick && hp[0];
   assign start   = ((st == ENG_IDLE) || gap_end) && ta && tx_valid;
   assign smp     = (st == ENG_SHIFT) && tick && (hp[0] == cpha);
   assign shf     = (st == ENG_SHIFT) && tick && (hp[0] != cpha) && !(cpha && hp == '0);
   assign rx_push = (st == ENG_SHIFT) && tick && (hp == LAST);
   assign rx_data = cpha ? {rxsr[WORD_W-2:0], din} : rxsr;
   assign tx_pop  = start;
   assign sclk    = (st == ENG_SHIFT) ? (cpol ^ hp[0]) : cpol;
   assign mosi    = txsr[WORD_W-1];
   assign busy    = (st != ENG_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ENG_IDLE;
         hp   <= '0;
         cnt  <= '0;
         txsr <= '0;
         rxsr <= '0;
      end else begin
         if (smp) rxsr <= {rxsr[WORD_W-2:0], din};
         if (shf) txsr <= {txsr[WORD_W-2:0], 1'b0};
         if (start) begin
            st   <= ENG_SHIFT;
            hp   <= '0;
            cnt  <= half_m1;
            txsr <= tx_data;
         end else begin
            case (st)
               ENG_SHIFT: begin
                  if (tick) begin
                     cnt <= half_m1;
                     if (hp == LAST) begin
                        st <= ENG_GAP;
                        hp <= '0;
                     end else begin
                        hp <= hp + HPW'(1);
                     end
                  end else begin
                     cnt <= cnt - 16'd1;
                  end
               end
               ENG_GAP: begin
                  if (tick) begin
                     cnt <= half_m1;
                     if (hp[0]) st <= ENG_IDLE;
                     else       hp <= hp + HPW'(1);
                  end else begin
                     cnt <= cnt - 16'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
   parameter int DEPTH   = 16,
   parameter int RX_NEED = 12,
   parameter int NUM_CS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe,
   input  logic              mosi_in,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_o
);
   import spim_pkg::*;

   localparam int WORD_W = 8;
   localparam int CW     = $clog2(DEPTH + 1);

   generate
      if (NUM_CS < 1 || NUM_CS > 3) begin : g_bad_cs
         $error("spim_ctrl: NUM_CS must be 1 to 3");
      end
      if (RX_NEED < 1 || RX_NEED > DEPTH) begin : g_bad_need
         $error("spim_ctrl: RX_NEED must lie within the FIFO depth");
      end
   endgenerate

   logic [1:0]  sel_q;
   logic        cpha_q, cpol_q, cspol_q, ta_q, intd_q, intr_q, ren_q;
   logic [2:0]  lpol_q;
   logic [15:0] div_q;

   logic wr_ctrl, wr_div, clr_tx, clr_rx, tx_push, rx_pop;
   logic tx_empty, tx_full, rx_empty, rx_full, rx_need, done;
   logic eng_busy, tx_pop, rx_push;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;

   assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
   assign wr_div  = bus_wr && (bus_addr == OFS_DIV);
   assign tx_push = bus_wr && (bus_addr == OFS_DATA);
   assign rx_pop  = bus_rd && (bus_addr == OFS_DATA);
   assign clr_tx  = wr_ctrl && bus_wdata[B_CLRTX];
   assign clr_rx  = wr_ctrl && bus_wdata[B_CLRRX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0; cpha_q <= 1'b0; cpol_q <= 1'b0; cspol_q <= 1'b0;
         ta_q <= 1'b0; intd_q <= 1'b0; intr_q <= 1'b0; ren_q <= 1'b0;
         lpol_q <= '0; div_q <= '0;
      end else begin
         if (wr_ctrl) begin
            sel_q   <= bus_wdata[1:0];
            cpha_q  <= bus_wdata[B_CPHA];
            cpol_q  <= bus_wdata[B_CPOL];
            cspol_q <= bus_wdata[B_GPOL];
            ta_q    <= bus_wdata[B_ACT];
            intd_q  <= bus_wdata[B_IEDN];
            intr_q  <= bus_wdata[B_IERX];
            ren_q   <= bus_wdata[B_RDEN];
            lpol_q  <= bus_wdata[B_LPOL+2:B_LPOL];
         end
         if (wr_div) div_q <= bus_wdata[15:0];
      end
   end

   spim_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .clr(clr_tx), .push(tx_push), .pop(tx_pop),
      .din(bus_wdata[WORD_W-1:0]), .dout(tx_head), .count(tx_cnt),
      .empty(tx_empty), .full(tx_full));

   spim_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(rx_push), .pop(rx_pop),
      .din(rx_word), .dout(rx_head), .count(rx_cnt),
      .empty(rx_empty), .full(rx_full));

   spim_engine #(.WORD_W(WORD_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .ta(ta_q), .cpol(cpol_q), .cpha(cpha_q),
      .div(div_q), .tx_valid(!tx_empty), .tx_data(tx_head),
      .din(ren_q ? mosi_in : miso), .tx_pop(tx_pop), .rx_push(rx_push),
      .rx_data(rx_word), .sclk(sclk), .mosi(mosi), .busy(eng_busy));

   assign rx_need = (rx_cnt >= CW'(RX_NEED));
   assign done    = ta_q && tx_empty && !eng_busy;
   assign irq     = (intd_q && done) || (intr_q && rx_need);
   assign mosi_oe = !ren_q;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      logic hit, pol;
      assign hit     = (sel_q == 2'(i));
      assign pol     = lpol_q[i] | (cspol_q & hit);
      assign cs_o[i] = (ta_q && hit) ? pol : !pol;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: bus_rdata = {8'd0, lpol_q, rx_full, rx_need, !tx_full, !rx_empty,
                                done, 3'd0, ren_q, 1'b0, intr_q, intd_q, 1'b0,
                                ta_q, cspol_q, 2'd0, cpol_q, cpha_q, sel_q};
         OFS_DATA: bus_rdata = {24'd0, rx_head};
         OFS_DIV:  bus_rdata = {16'd0, div_q};
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
   parameter int DEPTH  = 16,
   parameter int NUM_CS = 3,
   parameter int CW     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [7:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic              sclk,
   input logic              mosi_oe,
   input logic [NUM_CS-1:0] cs_o,
   input logic [1:0]        sel_q,
   input logic              ta_q,
   input logic              cpol_q,
   input logic              cspol_q,
   input logic              intd_q,
   input logic              ren_q,
   input logic [2:0]        lpol_q,
   input logic              done,
   input logic              eng_busy,
   input logic [CW-1:0]     tx_cnt,
   input logic [CW-1:0]     rx_cnt
);
   logic [NUM_CS-1:0] asserted;
   always_comb begin
      for (int i = 0; i < NUM_CS; i++) begin
         asserted[i] = (cs_o[i] == (lpol_q[i] | (cspol_q & (sel_q == 2'(i)))));
      end
   end

   // R8: never more than one line in its active state
   a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(asserted) <= 1);

   // R8: no line active while transfer-active is clear
   a_r8_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      !ta_q |-> (asserted == '0));

   // R10: done with its enable raises the interrupt
   a_r10_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
      (intd_q && done) |-> irq);

   // R3: levels stay within capacity
   a_r3_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

   // R7: clear-TX empties the transmit FIFO in the next cycle
   a_r7_clear_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h00 && bus_wdata[4]) |=> (tx_cnt == '0));

   // R11: read mode releases the data output
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      ren_q |-> !mosi_oe);

   // R4: clock at rest while no word is in flight
   a_r4_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (sclk == cpol_q));

   // R12: nothing starts while transfer-active is clear
   a_r12_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!ta_q && !eng_busy) |=> !eng_busy);
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .CW($clog2(DEPTH+1))) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq(irq), .sclk(sclk), .mosi_oe(mosi_oe),
   .cs_o(cs_o), .sel_q(sel_q), .ta_q(ta_q), .cpol_q(cpol_q),
   .cspol_q(cspol_q), .intd_q(intd_q), .ren_q(ren_q), .lpol_q(lpol_q),
   .done(done), .eng_busy(eng_busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sclk, mosi, mosi_oe, mosi_in, miso;
   logic [2:0]  cs_o;

   int checks = 0, errors = 0;
   bit loop_en = 1'b0, tw_en = 1'b0, cpol_b = 1'b0, cpha_b = 1'b0;
   logic [7:0] slv_sr = '0, slv_in = '0;
   logic       slv_bit = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mosi_in = slv_bit;
   assign miso    = loop_en ? mosi : (tw_en ? ~slv_bit : slv_bit);

   spim_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe),
      .mosi_in(mosi_in), .miso(miso), .cs_o(cs_o));

   // bench-side slave
   always @(posedge sclk or negedge sclk) begin
      if (sclk !== cpol_b) begin
         if (!cpha_b) slv_in = {slv_in[6:0], mosi};
         else begin slv_bit = slv_sr[7]; slv_sr = {slv_sr[6:0], 1'b0}; end
      end else begin
         if (!cpha_b) begin slv_sr = {slv_sr[6:0], 1'b0}; slv_bit = slv_sr[7]; end
         else slv_in = {slv_in[6:0], mosi};
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] mk(logic [1:0] sel, bit cpha, bit cpol, bit g, bit ta,
                                      bit idn, bit irx, bit ren, logic [2:0] lp, bit ctx, bit crx);
      logic [31:0] v = '0;
      v[1:0] = sel; v[2] = cpha; v[3] = cpol; v[4] = ctx; v[5] = crx; v[6] = g;
      v[7] = ta; v[9] = idn; v[10] = irx; v[12] = ren; v[23:21] = lp;
      return v;
   endfunction

   function automatic logic [2:0] exp_cs(logic [1:0] s, bit ta, bit g, logic [2:0] lp);
      logic [2:0] r;
      for (int i = 0; i < 3; i++) begin
         logic pol;
         pol  = lp[i] | (g & (s == 2'(i)));
         r[i] = (ta && s == 2'(i)) ? pol : ~pol;
      end
      return r;
   endfunction

   function automatic int half_of(int dv);
      if (dv == 0) return 32768;
      if ((dv >> 1) == 0) return 1;
      return dv >> 1;
   endfunction

   task automatic wait_done(input string tag);
      logic [31:0] s;
      int n = 0;
      rd(8'h00, s);
      while (!s[16] && n < 20000) begin rd(8'h00, s); n++; end
      if (n >= 20000) chk(1'b0, tag, s, 32'h0001_0000);
   endtask

   task automatic measure(input int dv, output int cyc);
      logic [31:0] s;
      wr(8'h08, dv);
      wr(8'h00, mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1));
      wr(8'h04, 32'h5A);
      cyc = 0;
      rd(8'h00, s);
      while (!s[16] && cyc < 20000) begin cyc++; rd(8'h00, s); end
   endtask

   task automatic slave_byte(input int mode, input logic [7:0] mtx, input logic [7:0] stx,
                             input bit three_w, input string tag);
      logic [31:0] r;
      wr(8'h08, 32'd4);
      wr(8'h00, mk(0, mode[0], mode[1], 0, 0, 0, 0, three_w, 0, 1, 1));
      cpha_b = mode[0]; cpol_b = mode[1]; tw_en = three_w; loop_en = 1'b0;
      slv_sr = stx; slv_bit = stx[7];
      wr(8'h00, mk(0, mode[0], mode[1], 0, 1, 0, 0, three_w, 0, 0, 0));
      if (three_w) chk(mosi_oe == 1'b0, {tag, " R11 oe"}, mosi_oe, 0);
      wr(8'h04, mtx);
      wait_done(tag);
      rd(8'h04, r);
      chk(r[7:0] == stx, {tag, " R6 master rx"}, r, stx);
      if (!three_w) chk(slv_in == mtx, {tag, " R5 slave rx msb-first"}, slv_in, mtx);
      chk(sclk == mode[1], {tag, " R4 rest level"}, sclk, mode[1]);
      wr(8'h00, mk(0, mode[0], mode[1], 0, 0, 0, 0, 0, 0, 0, 0));
      tw_en = 1'b0;
   endtask

   initial begin
      logic [31:0] r;
      int cyc;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, r);
      chk(r == 32'h0004_0000, "R1 ctrl word", r, 32'h0004_0000);
      chk(cs_o == 3'b111, "R1 cs lines", cs_o, 3'b111);
      chk(sclk == 1'b0 && irq == 1'b0 && mosi_oe == 1'b1, "R1 sclk/irq/oe",
          {sclk, irq, mosi_oe}, 3'b001);

      // R2 decode
      wr(8'h08, 32'h1234_ABCD);
      rd(8'h08, r);
      chk(r == 32'h0000_ABCD, "R2 divider readback", r, 32'h0000_ABCD);
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, r);
      chk(r == 0, "R2 unused 0x0C", r, 0);
      rd(8'h14, r);
      chk(r == 0, "R2 unused 0x14", r, 0);
      rd(8'h00, r);
      chk(r == 32'h0004_0000, "R2 unused write no effect", r, 32'h0004_0000);

      // R8 / R9 chip selects
      for (int k = 0; k < 12; k++) begin
         logic [1:0] s = 2'(k % 4);
         bit ta = (k % 3) != 0;
         bit g = k[2];
         logic [2:0] lp = 3'($urandom % 8);
         wr(8'h00, mk(s, 0, 0, g, ta, 0, 0, 0, lp, 0, 0));
         chk(cs_o == exp_cs(s, ta, g, lp), ta ? "R8 select lines" : "R9 inactive levels",
             cs_o, exp_cs(s, ta, g, lp));
      end
      wr(8'h00, mk(1, 0, 0, 0, 1, 0, 0, 0, 3'b010, 0, 0));
      chk(cs_o == 3'b111, "R9 line pol active-high", cs_o, 3'b111);
      wr(8'h00, mk(3, 0, 0, 0, 1, 0, 0, 0, 3'b000, 0, 0));
      chk(cs_o == 3'b111, "R8 code 3 none", cs_o, 3'b111);

      // R10 done and interrupt
      wr(8'h00, mk(0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1));
      rd(8'h00, r);
      chk(r[16] == 1'b1 && r[4] == 1'b0 && r[5] == 1'b0, "R10 done at activation / R7 readback 0", r, 32'h0001_0000);
      chk(irq == 1'b1, "R10 irq on done", irq, 1);
      wr(8'h00, mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0));
      chk(irq == 1'b0, "R10 irq masked", irq, 0);
      wr(8'h00, mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
      rd(8'h00, r);
      chk(r[16] == 1'b0 && irq == 1'b0, "R10 no done without active", {r[16], irq}, 0);

      // R3 FIFO capacity and flags
      loop_en = 1'b1;
      wr(8'h08, 32'd2);
      wr(8'h00, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1));
      for (int i = 0; i < 17; i++) wr(8'h04, 32'h10 + i);
      rd(8'h00, r);
      chk(r[18] == 1'b0, "R3 tx full flag", r[18], 0);
      wr(8'h00, mk(0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0));
      wait_done("R3 drain");
      rd(8'h00, r);
      chk(r[20:17] == 4'b1101 || r[20:17] == 4'b1111, "R3 rx flags full", r[20:17], 4'b1111);
      chk(r[20] && r[19] && r[17], "R3 rx full/need/data", r[20:17], 4'b1101);
      chk(irq == 1'b1, "R10 irq on rx need", irq, 1);
      for (int i = 0; i < 16; i++) begin
         rd(8'h04, r);
         chk(r[7:0] == 8'(32'h10 + i), "R3 rx order", r, 32'h10 + i);
         if (i == 3) begin
            rd(8'h00, r);
            chk(r[19] == 1'b1 && irq == 1'b1, "R3 need at 12", r[19], 1);
         end
         if (i == 4) begin
            rd(8'h00, r);
            chk(r[19] == 1'b0 && irq == 1'b0, "R3 need below 12", r[19], 0);
         end
      end
      rd(8'h00, r);
      chk(r[17] == 1'b0, "R3 17th push ignored, rx empty", r[17], 0);
      rd(8'h04, r);
      rd(8'h00, r);
      chk(r[17] == 1'b0 && r[16] == 1'b1, "R3 pop on empty ignored", r[17:16], 2'b01);

      // R7 clear RX and TX
      for (int i = 0; i < 3; i++) wr(8'h04, 32'hA0 + i);
      wait_done("R7 fill");
      wr(8'h00, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
      rd(8'h00, r);
      chk(r[17] == 1'b0 && r[5] == 1'b0, "R7 clear rx", r, 0);
      for (int i = 0; i < 16; i++) wr(8'h04, i);
      wr(8'h00, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
      rd(8'h00, r);
      chk(r[18] == 1'b1 && r[4] == 1'b0, "R7 clear tx", r, 32'h0004_0000);
      wr(8'h00, mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0));
      rd(8'h00, r);
      chk(r[16] == 1'b1, "R7 cleared tx sends nothing", r[16], 1);

      // R4 / R5 word timing
      measure(4, cyc);
      chk(cyc == 9 * 4 + 1, "R5 word time D=4", cyc, 37);
      measure(3, cyc);
      chk(cyc == 9 * 2 + 1, "R4 odd divider rounds down", cyc, 19);
      measure(1, cyc);
      chk(cyc == 9 * 2 + 1, "R4 minimum divider", cyc, 19);
      measure(10, cyc);
      chk(cyc == 18 * half_of(10) + 1, "R5 word time D=10", cyc, 91);
      wr(8'h00, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1));

      // R6 modes with slave, R11 three-wire
      for (int m = 0; m < 4; m++) begin
         logic [7:0] a = 8'($urandom), b = 8'($urandom);
         slave_byte(m, a, b, 1'b0, "mode");
         slave_byte(m, 8'hC3, 8'h81, 1'b0, "mode fixed");
      end
      slave_byte(0, 8'hFF, 8'h6B, 1'b1, "R11 three-wire m0");
      slave_byte(3, 8'h00, 8'hD4, 1'b1, "R11 three-wire m3");

      // R12 deactivate mid-word
      loop_en = 1'b1;
      cpol_b = 1'b1;
      wr(8'h08, 32'd4);
      wr(8'h00, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1));
      wr(8'h04, 32'h3C);
      wr(8'h04, 32'h99);
      wr(8'h00, mk(0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0));
      repeat (8) @(negedge clk);
      wr(8'h00, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
      repeat (80) @(negedge clk);
      chk(sclk == 1'b1, "R12 rest level after stop", sclk, 1);
      rd(8'h04, r);
      chk(r[7:0] == 8'h3C, "R12 word in flight finished", r, 32'h3C);
      rd(8'h00, r);
      chk(r[17] == 1'b0 && r[18] == 1'b1, "R12 no second word", r[18:17], 2'b10);
      wr(8'h00, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1));

      // random loopback streams
      for (int it = 0; it < 8; it++) begin
         int n = 1 + ($urandom % 8);
         int m = $urandom % 4;
         int dv = 2 + ($urandom % 5);
         logic [7:0] q [8];
         wr(8'h08, dv);
         wr(8'h00, mk(0, m[0], m[1], 0, 0, 0, 0, 0, 0, 1, 1));
         wr(8'h00, mk(0, m[0], m[1], 0, 1, 0, 0, 0, 0, 0, 0));
         for (int i = 0; i < n; i++) begin
            q[i] = 8'($urandom);
            wr(8'h04, q[i]);
         end
         wait_done("R5 stream");
         for (int i = 0; i < n; i++) begin
            rd(8'h04, r);
            chk(r[7:0] == q[i], "R6 loopback stream", r, q[i]);
         end
         rd(8'h00, r);
         chk(r[17] == 1'b0, "R3 stream count", r[17], 0);
      end

      // R4 divider 0 means 65536
      wr(8'h00, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1));
      cpol_b = 1'b0;
      wr(8'h08, 32'd0);
      wr(8'h00, mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0));
      wr(8'h04, 32'h11);
      cyc = 0;
      while (sclk == 1'b0 && cyc < 40000) begin cyc++; @(negedge clk); end
      chk(cyc == 1 + 32768, "R4 zero divider half period", cyc, 32769);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h00, r);
      chk(r == 32'h0004_0000 && sclk == 1'b0, "R1 state after second reset", r, 32'h0004_0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule